// File: doc/BRIEF.md
# Host Register Slave Port

This block is the processor-facing slave port of a network controller. A host that runs on its own clock reaches sixteen 8-bit control registers through it. The host first presents a 4-bit register number. It then drops chip select and one of two active-low strobes, one for reads and one for writes. It waits for an active-low acknowledge before it ends the cycle.

The register number passes through a transparent latch. The latch follows its inputs while the address strobe is high and freezes on the strobe's falling edge. Each host request passes through a two-flop synchronizer into the controller clock. Acknowledge is granted only once the request has crossed, so the host sits in wait states until then.

Read data is driven on the low byte lane only while the read request is live. Write data is sampled while the write request is live. It is committed to the selected register after the synchronized release of the write strobe. The upper byte lane never drives during register traffic. While the controller's DMA engine owns the bus, the port ignores the host.

Top module: `host_reg_port`

## Requirements
- R1: After reset, ack_no is 1, data_oe_o is all zero, and every one of the 16 registers reads back 0x00.
- R2: While ras_i is 1, radr_i selects the register directly (a read follows changes of radr_i). On the falling edge of ras_i the number is frozen, and later changes of radr_i while ras_i is 0 select nothing else.
- R3: A request is live only while cs_ni is 0 and dma_busy_i is 0. Without a live request, strobes produce no acknowledge, no drive and no register write.
- R4: data_oe_o[15:8] and data_o[15:8] are always 0.
- R5: During a live write (hwr_ni low), the value on data_i[7:0] is stored into the latched register. It becomes readable no later than three clock edges after hwr_ni rises.
- R6: During a live read (hrd_ni low), data_oe_o[7:0] is 0xFF and data_o[7:0] shows the selected register, with no clock edge needed. Once the read request ends, data_oe_o[7:0] is 0x00.
- R7: ack_no falls after the third rising clock edge that sees a live request, and stays high before that edge.
- R8: ack_no returns to 1 without waiting for a clock edge when the strobe or cs_ni is released.
- R9: A write changes only the selected register; all others keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_i | input | 1 | Address strobe; latch open while high |
| radr_i | input | 4 | Register number from host |
| cs_ni | input | 1 | Chip select, active low |
| dma_busy_i | input | 1 | DMA engine owns the bus; blocks host access |
| hrd_ni | input | 1 | Host read strobe, active low |
| hwr_ni | input | 1 | Host write strobe, active low |
| data_i | input | 16 | Bus value seen at the pins |
| data_o | output | 16 | Value to drive on the bus |
| data_oe_o | output | 16 | Per-line drive enable; 0 floats the line |
| ack_no | output | 1 | Acknowledge to host, active low |

## Verification
The synchronizer and acknowledge flops are the state that can go wrong unseen. A wrong value there shows on ack_no within one clock: acknowledge comes a cycle early or late against the third-edge rule, or hangs low after the strobe is released. A corrupted write pulse or latched register number shows on the next read of the affected register, or of its neighbours, as a wrong byte on data_o[7:0]. A fault in the drive control shows at once on data_oe_o, whenever a read is ended or blocked by DMA.

// File: rtl/host_reg_pkg.sv
package host_reg_pkg;
  localparam int unsigned N_STB  = 2;
  localparam int unsigned STB_RD = 0;
  localparam int unsigned STB_WR = 1;
endpackage

// File: rtl/hrp_sync.sv
module hrp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end
  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/hrp_ack_gen.sv
module hrp_ack_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_live_i,
  input  logic req_sync_i,
  output logic ack_no
);
  logic sync_d_q, ack_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_d_q <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      sync_d_q <= req_sync_i;
      // grant only on a fresh synchronized edge; hold while request stays live
      ack_q    <= req_sync_i & req_live_i & (ack_q | ~sync_d_q);
    end
  end
  assign ack_no = ~(ack_q & req_live_i);
endmodule

// File: rtl/hrp_regfile.sv
module hrp_regfile #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wadr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] radr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned NREG = 1 << AW;
  logic [DW-1:0] mem_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[g] <= '0;
      else if (we_i && wadr_i == AW'(g))    mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[radr_i];
endmodule

// File: rtl/host_reg_port.sv
module host_reg_port
  import host_reg_pkg::*;
#(
  parameter int unsigned AW          = 4,
  parameter int unsigned DW          = 8,
  parameter int unsigned BW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ras_i,
  input  logic [AW-1:0] radr_i,
  input  logic          cs_ni,
  input  logic          dma_busy_i,
  input  logic          hrd_ni,
  input  logic          hwr_ni,
  input  logic [BW-1:0] data_i,
  output logic [BW-1:0] data_o,
  output logic [BW-1:0] data_oe_o,
  output logic          ack_no
);
  localparam int unsigned UW = BW - DW;

  logic             sel;
  logic [N_STB-1:0] req_raw, req_sync, req_sync_d_q;
  logic [AW-1:0]    adr_q;
  logic [DW-1:0]    wdata_q, rdata;
  logic             commit;

  assign sel              = ~cs_ni & ~dma_busy_i;
  assign req_raw[STB_RD]  = sel & ~hrd_ni;
  assign req_raw[STB_WR]  = sel & ~hwr_ni;

  for (genvar g = 0; g < N_STB; g++) begin : g_sync
    hrp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (req_raw[g]),
      .q_o    (req_sync[g])
    );
  end

  // transparent address latch, frozen on falling ras_i
  always_latch begin
    if (!rst_ni)    adr_q <= '0;
    else if (ras_i) adr_q <= radr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_sync_d_q <= '0;
      wdata_q      <= '0;
    end else begin
      req_sync_d_q <= req_sync;
      if (req_raw[STB_WR]) wdata_q <= data_i[DW-1:0];
    end
  end

  assign commit = req_sync_d_q[STB_WR] & ~req_sync[STB_WR];

  hrp_regfile #(.AW(AW), .DW(DW)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (commit),
    .wadr_i  (adr_q),
    .wdata_i (wdata_q),
    .radr_i  (adr_q),
    .rdata_o (rdata)
  );

  hrp_ack_gen u_ack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_live_i (|req_raw),
    .req_sync_i (|req_sync),
    .ack_no     (ack_no)
  );

  assign data_o    = {{UW{1'b0}}, req_raw[STB_RD] ? rdata : {DW{1'b0}}};
  assign data_oe_o = {{UW{1'b0}}, {DW{req_raw[STB_RD]}}};
endmodule

// File: rtl/host_reg_port_chk.sv
module host_reg_port_chk #(
  parameter int unsigned BW = 16,
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_ni,
  input logic          dma_busy_i,
  input logic          hrd_ni,
  input logic          hwr_ni,
  input logic [BW-1:0] data_oe_o,
  input logic          ack_no
);
  logic req;
  assign req = !cs_ni && !dma_busy_i && (!hrd_ni || !hwr_ni);

  a_r4_upper_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o[BW-1:DW] == '0);

  a_r3_no_drive_unselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || dma_busy_i) |-> (data_oe_o == '0 && ack_no));

  a_r8_ack_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req |-> ack_no);

  a_r7_ack_after_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_no && $past(ack_no)) |-> ($past(req, 2) && $past(req)));

  a_r6_drive_only_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o[DW-1:0] != '0) |-> (!hrd_ni && !cs_ni && !dma_busy_i));
endmodule

bind host_reg_port host_reg_port_chk #(.BW(BW), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .dma_busy_i (dma_busy_i),
  .hrd_ni     (hrd_ni),
  .hwr_ni     (hwr_ni),
  .data_oe_o  (data_oe_o),
  .ack_no     (ack_no)
);

// File: tb/tb_host_reg_port.sv
`timescale 1ns/1ps
module tb_host_reg_port;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        ras = 1'b1, cs_n = 1'b1, dma = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0]  radr = '0;
  logic [15:0] din = '0, dout, oe;
  logic        ack_n;
  int          n_chk = 0, n_fail = 0;
  logic [7:0]  model [16];

  always #2.5 clk = ~clk;

  host_reg_port dut (
    .clk_i(clk), .rst_ni(rst_ni), .ras_i(ras), .radr_i(radr), .cs_ni(cs_n),
    .dma_busy_i(dma), .hrd_ni(rd_n), .hwr_ni(wr_n), .data_i(din),
    .data_o(dout), .data_oe_o(oe), .ack_no(ack_n)
  );

  localparam int NV = 8;
  localparam logic [11:0] VEC [NV] = '{
    12'h0_A5, 12'hF_3C, 12'h7_FF, 12'h1_01,
    12'h8_80, 12'h0_5A, 12'hE_00, 12'h3_C3
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_adr(input logic [3:0] a);
    @(negedge clk); ras = 1'b1; radr = a;
    @(negedge clk); ras = 1'b0; radr = ~a;
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d, input bit busy);
    set_adr(a);
    dma = busy; din = {8'hEE, d}; cs_n = 1'b0; wr_n = 1'b0;
    repeat (5) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
    dma = 1'b0; din = 16'h1234;
  endtask

  task automatic do_read(input logic [3:0] a, input logic [7:0] exp, input string tag);
    set_adr(a);
    cs_n = 1'b0; rd_n = 1'b0;
    #1;
    chk(oe == 16'h00FF, {tag, " R6 oe"}, oe, 16'h00FF);
    chk(dout == {8'h00, exp}, {tag, " data"}, dout, {8'h00, exp});
    @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;
    #1;
    chk(oe == 16'h0000, "R6 float after read", oe, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ack_n === 1'b1, "R1 ack idle", ack_n, 1);
    chk(oe === 16'h0, "R1 oe idle", oe, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) do_read(4'(i), 8'h00, "R1 reset value");

    // R5/R9 vector table: writes then read-back against model
    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][11:8], VEC[i][7:0], 1'b0);
      model[VEC[i][11:8]] = VEC[i][7:0];
    end
    for (int i = 0; i < 16; i++) do_read(4'(i), model[i], "R5 R9 readback");

    // R7 ack timing, R4 upper lane
    set_adr(4'hF);
    cs_n = 1'b0; rd_n = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk(ack_n == 1'b1, "R7 ack held before sync", ack_n, 1);
    @(posedge clk); #1;
    chk(ack_n == 1'b0, "R7 ack at third edge", ack_n, 0);
    chk(oe[15:8] == 8'h00 && dout[15:8] == 8'h00, "R4 upper lane float", oe, 16'h00FF);
    @(negedge clk); rd_n = 1'b1; #1;
    chk(ack_n == 1'b1, "R8 ack release on strobe", ack_n, 1);
    @(negedge clk); rd_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(ack_n == 1'b0, "R7 ack second access", ack_n, 0);
    cs_n = 1'b1; #1;
    chk(ack_n == 1'b1, "R8 ack release on cs", ack_n, 1);
    rd_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 write blocked by DMA, strobes ignored without cs
    do_write(4'h7, 8'h11, 1'b1);
    do_read(4'h7, model[7], "R3 dma write ignored");
    set_adr(4'h2);
    dma = 1'b1; cs_n = 1'b0; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(ack_n == 1'b1 && oe == 16'h0, "R3 dma blocks read", {ack_n, oe}, 17'h10000);
    dma = 1'b0; cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk); wr_n = 1'b0; din = 16'h0099;
    repeat (4) @(negedge clk);
    chk(ack_n == 1'b1 && oe == 16'h0, "R3 no cs no ack", {ack_n, oe}, 17'h10000);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    do_read(4'h2, model[2], "R3 no-cs write ignored");

    // R2 transparent latch then hold
    @(negedge clk); ras = 1'b1; radr = 4'h0; cs_n = 1'b0; rd_n = 1'b0; #1;
    chk(dout[7:0] == model[0], "R2 transparent a", dout[7:0], model[0]);
    radr = 4'hF; #1;
    chk(dout[7:0] == model[15], "R2 transparent b", dout[7:0], model[15]);
    ras = 1'b0; #1; radr = 4'h7; #1;
    chk(dout[7:0] == model[15], "R2 hold after fall", dout[7:0], model[15]);
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule